// File: doc/BRIEF.md
# Triple Match and Wrap Timer Peripheral

This peripheral holds three independent counters behind a single-cycle register port (address, write strobe, write data, combinational read data). Each counter can be started and stopped, can count up or down, and can advance either on every bus clock or once per rising edge of an external tick. The external tick passes through a synchroniser before it is used. Each counter has a reload value and two compare values.

Every counter produces three events: compare A hit, compare B hit and wrap. The nine events are collected in a shared sticky status word. A shared mask word and a per-counter interrupt-enable bit decide which of them reach the single interrupt line. Software typically uses one counter as a periodic tick by loading it near the top of its range in up mode. It uses another as a one-shot by setting compare A to the current count plus a delay.

Top module: `trio_timer`

## Requirements
- R1: Counter n (0..2) exposes its count at byte address 0x10·n, its reload value at 0x10·n+4, compare A at 0x10·n+8 and compare B at 0x10·n+0xC. The control word is at 0x30, the status word at 0x34 and the mask word at 0x38. Every register reads back what was last written, within its width: 32 bits for counter registers, 12 for control, 9 for status and mask. Any other address reads as 0.
- R2: In the control word, counter n uses bit 3n as run enable, bit 3n+1 as source select (1 = external tick, 0 = bus clock) and bit 3n+2 as interrupt enable. Bit 9+n selects up counting (1) or down counting (0).
- R3: An up-counting counter advances by one per step. A step taken from 0xFFFFFFFF loads the reload value instead and sets its wrap status bit, 3n+2.
- R4: A down-counting counter decreases by one per step. A step taken from 0 loads the reload value instead and sets its wrap status bit.
- R5: When a step produces a count equal to compare A, status bit 3n is set. When it equals compare B, status bit 3n+1 is set. The comparison uses the compare values held before any write in the same cycle.
- R6: A counter whose run enable is 0 holds its count. The count is writable at any time, and a count write overrides a step in the same cycle and raises no event.
- R7: With source select at 1, the counter takes one step per rising edge of ext_tick. If ext_tick is sampled high at clock edge k and was low at edge k-1, the step lands on edge k+2.
- R8: Status bits are set by their events whatever the mask holds. Writing 0 to a status bit clears it, writing 1 leaves it, and an event in the same cycle as a clear wins.
- R9: irq is 1 exactly when, for some counter n, control bit 3n+2 is 1 and some status bit of that counter has its mask bit at 0. A mask bit of 1 blocks its event.
- R10: After reset all counts, reload values, compare values, control and status are 0, the mask word is 0x1FF and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | Asynchronous external tick, rising edges counted |
| reg_addr | input | 6 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives each counter across both ends of its range in both directions. A design that compares against 0xFFFFFFFF one step late, or that reloads with a freshly written reload value, drifts from the model at the wrap. It also targets collisions within a single cycle: a count write against a step, a status clear against a new event, and a compare write against a hit. Getting any of these priorities wrong leaves a status bit stale or raises a phantom event. External-tick runs check that the step lands on exactly the third edge and that a held-high tick gives one step, so a missing edge detector or a wrong synchroniser depth appears as a count error. Random traffic over the mask and enable bits checks that irq follows the per-counter gating and never a global OR.

// File: rtl/trio_timer_pkg.sv
package trio_timer_pkg;
   localparam int unsigned TMR_STRIDE  = 16;
   localparam int unsigned OFS_COUNT   = 0;
   localparam int unsigned OFS_LOAD    = 4;
   localparam int unsigned OFS_MATCH_A = 8;
   localparam int unsigned OFS_MATCH_B = 12;
   localparam int unsigned OFS_CTRL    = 0;
   localparam int unsigned OFS_STATUS  = 4;
   localparam int unsigned OFS_MASK    = 8;
   localparam int unsigned EV_PER_TMR  = 3;
   localparam int unsigned EV_MATCH_A  = 0;
   localparam int unsigned EV_MATCH_B  = 1;
   localparam int unsigned EV_WRAP     = 2;
endpackage

// File: rtl/trio_tick_sync.sv
module trio_tick_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("trio_tick_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         last  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/trio_counter.sv
module trio_counter
   import trio_timer_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  count_up,
   input  logic                  wr_cnt,
   input  logic                  wr_load,
   input  logic                  wr_ma,
   input  logic                  wr_mb,
   input  logic [W-1:0]          wdata,
   output logic [W-1:0]          cnt,
   output logic [W-1:0]          load_q,
   output logic [W-1:0]          ma_q,
   output logic [W-1:0]          mb_q,
   output logic [EV_PER_TMR-1:0] ev
);
   localparam logic [W-1:0] TOP = '1;
   localparam logic [W-1:0] BOT = '0;
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic         step;
   logic         at_end;
   logic [W-1:0] nxt;

   assign step   = run & ~wr_cnt;
   assign at_end = count_up ? (cnt == TOP) : (cnt == BOT);

   always_comb begin
      if (at_end)        nxt = load_q;
      else if (count_up) nxt = cnt + ONE;
      else               nxt = cnt - ONE;
   end

   always_comb begin
      ev             = '0;
      ev[EV_MATCH_A] = step & (nxt == ma_q);
      ev[EV_MATCH_B] = step & (nxt == mb_q);
      ev[EV_WRAP]    = step & at_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         load_q <= '0;
         ma_q   <= '0;
         mb_q   <= '0;
      end else begin
         if (wr_cnt)    cnt <= wdata;
         else if (step) cnt <= nxt;
         if (wr_load) load_q <= wdata;
         if (wr_ma)   ma_q   <= wdata;
         if (wr_mb)   mb_q   <= wdata;
      end
   end
endmodule

// File: rtl/trio_irq_ctrl.sv
module trio_irq_ctrl
   import trio_timer_pkg::*;
#(
   parameter int unsigned NUM_TIMERS = 3,
   localparam int unsigned EV_W = EV_PER_TMR * NUM_TIMERS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [EV_W-1:0]       ev,
   input  logic                  wr_status,
   input  logic                  wr_mask,
   input  logic [EV_W-1:0]       wbits,
   input  logic [NUM_TIMERS-1:0] ie,
   output logic [EV_W-1:0]       status_q,
   output logic [EV_W-1:0]       mask_q,
   output logic                  irq
);
   logic [NUM_TIMERS-1:0] per_tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '1;
      end else begin
         if (wr_status) status_q <= (status_q & wbits) | ev;
         else           status_q <= status_q | ev;
         if (wr_mask)   mask_q   <= wbits;
      end
   end

   genvar n;
   generate
      for (n = 0; n < NUM_TIMERS; n++) begin : g_gate
         assign per_tmr[n] = ie[n] &
            (|(status_q[EV_PER_TMR*n +: EV_PER_TMR] & ~mask_q[EV_PER_TMR*n +: EV_PER_TMR]));
      end
   endgenerate

   assign irq = |per_tmr;
endmodule

// File: rtl/trio_timer.sv
module trio_timer
   import trio_timer_pkg::*;
#(
   parameter int unsigned NUM_TIMERS  = 3,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_tick,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic              irq
);
   localparam int unsigned EV_W        = EV_PER_TMR * NUM_TIMERS;
   localparam int unsigned CTRL_W      = EV_W + NUM_TIMERS;
   localparam int unsigned UP_BASE     = EV_W;
   localparam int unsigned COMMON_BASE = TMR_STRIDE * NUM_TIMERS;

   generate
      if (NUM_TIMERS < 1 || NUM_TIMERS > 5) begin : g_bad_num
         $error("trio_timer supports 1 to 5 counters");
      end
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("trio_timer data width too narrow for control word");
      end
      if ((1 << ADDR_W) <= COMMON_BASE + OFS_MASK) begin : g_bad_addr
         $error("trio_timer address width too small for register map");
      end
   endgenerate

   logic [CTRL_W-1:0]     ctrl_q;
   logic [EV_W-1:0]       ev_all;
   logic [EV_W-1:0]       status_q;
   logic [EV_W-1:0]       mask_q;
   logic [NUM_TIMERS-1:0] ie;
   logic                  tick_rise;
   logic [CNT_W-1:0]      cnt_a  [NUM_TIMERS];
   logic [CNT_W-1:0]      load_a [NUM_TIMERS];
   logic [CNT_W-1:0]      ma_a   [NUM_TIMERS];
   logic [CNT_W-1:0]      mb_a   [NUM_TIMERS];

   logic wr_ctrl, wr_status, wr_mask;
   assign wr_ctrl   = reg_we && (reg_addr == ADDR_W'(COMMON_BASE + OFS_CTRL));
   assign wr_status = reg_we && (reg_addr == ADDR_W'(COMMON_BASE + OFS_STATUS));
   assign wr_mask   = reg_we && (reg_addr == ADDR_W'(COMMON_BASE + OFS_MASK));

   trio_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_tick),
      .rise     (tick_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
   end

   genvar n;
   generate
      for (n = 0; n < NUM_TIMERS; n++) begin : g_tmr
         localparam int unsigned BASE = TMR_STRIDE * n;
         logic src_ext, run;
         assign src_ext = ctrl_q[EV_PER_TMR*n + 1];
         assign run     = ctrl_q[EV_PER_TMR*n] & (src_ext ? tick_rise : 1'b1);
         assign ie[n]   = ctrl_q[EV_PER_TMR*n + 2];

         trio_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .count_up (ctrl_q[UP_BASE + n]),
            .wr_cnt   (reg_we && (reg_addr == ADDR_W'(BASE + OFS_COUNT))),
            .wr_load  (reg_we && (reg_addr == ADDR_W'(BASE + OFS_LOAD))),
            .wr_ma    (reg_we && (reg_addr == ADDR_W'(BASE + OFS_MATCH_A))),
            .wr_mb    (reg_we && (reg_addr == ADDR_W'(BASE + OFS_MATCH_B))),
            .wdata    (reg_wdata),
            .cnt      (cnt_a[n]),
            .load_q   (load_a[n]),
            .ma_q     (ma_a[n]),
            .mb_q     (mb_a[n]),
            .ev       (ev_all[EV_PER_TMR*n +: EV_PER_TMR])
         );
      end
   endgenerate

   trio_irq_ctrl #(.NUM_TIMERS(NUM_TIMERS)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev_all),
      .wr_status (wr_status),
      .wr_mask   (wr_mask),
      .wbits     (reg_wdata[EV_W-1:0]),
      .ie        (ie),
      .status_q  (status_q),
      .mask_q    (mask_q),
      .irq       (irq)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < int'(NUM_TIMERS); i++) begin
         if (reg_addr == ADDR_W'(TMR_STRIDE*i + OFS_COUNT))   reg_rdata = cnt_a[i];
         if (reg_addr == ADDR_W'(TMR_STRIDE*i + OFS_LOAD))    reg_rdata = load_a[i];
         if (reg_addr == ADDR_W'(TMR_STRIDE*i + OFS_MATCH_A)) reg_rdata = ma_a[i];
         if (reg_addr == ADDR_W'(TMR_STRIDE*i + OFS_MATCH_B)) reg_rdata = mb_a[i];
      end
      if (reg_addr == ADDR_W'(COMMON_BASE + OFS_CTRL))   reg_rdata = CNT_W'(ctrl_q);
      if (reg_addr == ADDR_W'(COMMON_BASE + OFS_STATUS)) reg_rdata = CNT_W'(status_q);
      if (reg_addr == ADDR_W'(COMMON_BASE + OFS_MASK))   reg_rdata = CNT_W'(mask_q);
   end
endmodule

// File: rtl/trio_timer_chk.sv
module trio_timer_chk #(
   parameter int unsigned NUM_TIMERS = 3,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned ADDR_W     = 6,
   localparam int unsigned EV_W      = 3 * NUM_TIMERS,
   localparam int unsigned CTRL_W    = EV_W + NUM_TIMERS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [EV_W-1:0]   status_q,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt0,
   input logic [CNT_W-1:0]  load0
);
   localparam logic [CNT_W-1:0] TOP = '1;
   logic any_ie, wr_cnt0, wr_stat;

   always_comb begin
      any_ie = 1'b0;
      for (int i = 0; i < int'(NUM_TIMERS); i++) any_ie = any_ie | ctrl_q[3*i + 2];
   end
   assign wr_cnt0 = reg_we && (reg_addr == '0);
   assign wr_stat = reg_we && (reg_addr == ADDR_W'(16*NUM_TIMERS + 4));

   // R9: no interrupt without an enabled counter
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !any_ie |-> !irq);

   // R8: status bits only fall through a status write
   p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R6: stopped counter holds
   p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[0] && !wr_cnt0) |=> $stable(cnt0));

   // R3: up wrap reloads and flags
   p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && !ctrl_q[1] && ctrl_q[EV_W] && cnt0 == TOP && !wr_cnt0)
      |=> (cnt0 == $past(load0) && status_q[2]));

   // R4: down wrap reloads and flags
   p_wrap_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && !ctrl_q[1] && !ctrl_q[EV_W] && cnt0 == '0 && !wr_cnt0)
      |=> (cnt0 == $past(load0) && status_q[2]));
endmodule

bind trio_timer trio_timer_chk #(
   .NUM_TIMERS (NUM_TIMERS),
   .CNT_W      (CNT_W),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .ctrl_q   (ctrl_q),
   .status_q (status_q),
   .irq      (irq),
   .cnt0     (cnt_a[0]),
   .load0    (load_a[0])
);

// File: tb/tb_trio_timer.sv
module tb_trio_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_tick = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int fails = 0;
   bit checking = 0;
   int rot = 0;

   always #10 clk = ~clk;

   trio_timer dut (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_cnt [3];
   logic [31:0] m_load [3];
   logic [31:0] m_ma [3];
   logic [31:0] m_mb [3];
   logic [11:0] m_ctrl;
   logic [8:0]  m_stat, m_mask;
   bit          hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < 3; n++) begin
            m_cnt[n] = 0; m_load[n] = 0; m_ma[n] = 0; m_mb[n] = 0;
         end
         m_ctrl = 0; m_stat = 0; m_mask = 9'h1FF;
         hist = {1'b0, 1'b0, 1'b0};
      end else begin
         bit pulse;
         logic [8:0] ev;
         logic [31:0] nc [3];
         pulse = hist[1] && !hist[0];
         hist.push_back(ext_tick);
         void'(hist.pop_front());
         ev = 0;
         for (int n = 0; n < 3; n++) begin
            bit en, src, up, adv, edge_hit;
            logic [31:0] nv;
            en = m_ctrl[3*n]; src = m_ctrl[3*n+1]; up = m_ctrl[9+n];
            adv = en && (src ? pulse : 1'b1);
            nc[n] = m_cnt[n];
            if (reg_we && reg_addr == 6'(16*n)) nc[n] = reg_wdata;
            else if (adv) begin
               edge_hit = up ? (m_cnt[n] == 32'hFFFF_FFFF) : (m_cnt[n] == 0);
               if (edge_hit) nv = m_load[n];
               else if (up) nv = m_cnt[n] + 1;
               else nv = m_cnt[n] - 1;
               nc[n] = nv;
               if (edge_hit) ev[3*n+2] = 1;
               if (nv == m_ma[n]) ev[3*n] = 1;
               if (nv == m_mb[n]) ev[3*n+1] = 1;
            end
         end
         if (reg_we && reg_addr == 6'h34) m_stat = m_stat & reg_wdata[8:0];
         m_stat = m_stat | ev;
         for (int n = 0; n < 3; n++) begin
            if (reg_we && reg_addr == 6'(16*n+4))  m_load[n] = reg_wdata;
            if (reg_we && reg_addr == 6'(16*n+8))  m_ma[n]   = reg_wdata;
            if (reg_we && reg_addr == 6'(16*n+12)) m_mb[n]   = reg_wdata;
            m_cnt[n] = nc[n];
         end
         if (reg_we && reg_addr == 6'h30) m_ctrl = reg_wdata[11:0];
         if (reg_we && reg_addr == 6'h38) m_mask = reg_wdata[8:0];
      end
   end

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      if (a < 6'h30) begin
         case (a[3:0])
            4'h0: return m_cnt[a[5:4]];
            4'h4: return m_load[a[5:4]];
            4'h8: return m_ma[a[5:4]];
            4'hC: return m_mb[a[5:4]];
            default: return 0;
         endcase
      end
      if (a == 6'h30) return {20'h0, m_ctrl};
      if (a == 6'h34) return {23'h0, m_stat};
      if (a == 6'h38) return {23'h0, m_mask};
      return 0;
   endfunction

   function automatic bit exp_irq();
      bit r = 0;
      for (int n = 0; n < 3; n++)
         if (m_ctrl[3*n+2] && ((m_stat[3*n +: 3] & ~m_mask[3*n +: 3]) != 0)) r = 1;
      return r;
   endfunction

   function automatic string tag(input logic [5:0] a);
      if (a < 6'h30 && a[3:0] == 4'h0) return "R3 R4 R6 R7 count";
      if (a < 6'h30 && a[1:0] == 2'b00) return "R1 R5 load/compare";
      if (a == 6'h30) return "R2 control";
      if (a == 6'h34) return "R5 R8 status";
      if (a == 6'h38) return "R1 mask";
      return "R1 unmapped";
   endfunction

   task automatic compare(input string pre);
      logic [31:0] e;
      e = exp_rd(reg_addr);
      checks++;
      if (reg_rdata !== e) begin
         fails++;
         $display("FAIL %s %s addr=%h actual=%h expected=%h", pre, tag(reg_addr), reg_addr, reg_rdata, e);
      end
      checks++;
      if (irq !== exp_irq()) begin
         fails++;
         $display("FAIL %s R9 irq actual=%b expected=%b", pre, irq, exp_irq());
      end
   endtask

   task automatic step(input bit we, input logic [5:0] a, input logic [31:0] d, input bit ext);
      @(negedge clk);
      if (checking) compare("");
      reg_we = we; reg_addr = a; reg_wdata = d; ext_tick = ext;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      step(1, a, d, ext_tick);
   endtask

   task automatic idle(input int cycles, input int ext_period);
      for (int i = 0; i < cycles; i++) begin
         bit e;
         e = (ext_period == 0) ? ext_tick : bit'((i / ext_period) % 2);
         step(0, 6'(rot * 4), 0, e);
         rot = (rot + 1) % 16;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset values across the whole map
      for (int a = 0; a < 16; a++) begin
         reg_addr = 6'(a * 4);
         #1;
         compare("R10 reset");
      end
      rst_n = 1'b1;
      checking = 1;
      idle(4, 0);

      // R3: periodic up counting with wrap every 4 steps
      wr(6'h04, 32'hFFFF_FFFC);
      wr(6'h00, 32'hFFFF_FFFC);
      wr(6'h38, 9'h1FB);
      wr(6'h30, 12'h205);
      idle(20, 0);
      wr(6'h34, 9'h1FF);              // R8: writing ones keeps status
      idle(3, 0);
      wr(6'h34, 9'h1FB);              // R8: clear wrap bit, may race a new event
      idle(6, 0);

      // R4 R5: counter 1 down with compares
      wr(6'h10, 32'd10);
      wr(6'h14, 32'd5);
      wr(6'h18, 32'd7);
      wr(6'h1C, 32'd3);
      wr(6'h38, 9'h1E3);
      wr(6'h30, 12'h22D);
      idle(30, 0);

      // R6: stop counter 1, write while stopped, then write while running
      wr(6'h30, 12'h205);
      idle(6, 0);
      wr(6'h10, 32'h1234);
      idle(4, 0);
      wr(6'h30, 12'h22D);
      wr(6'h10, 32'd0);
      idle(6, 0);

      // R7: counter 2 on external tick, up, compare A at 2
      wr(6'h20, 32'd0);
      wr(6'h24, 32'd0);
      wr(6'h28, 32'd2);
      wr(6'h38, 9'h000);
      wr(6'h30, 12'hBED);
      idle(40, 3);
      idle(12, 0);                    // tick held: no further steps
      idle(40, 1);

      // R8 R9: mask and enable combinations
      wr(6'h34, 9'h000);
      wr(6'h38, 9'h1FF);
      idle(8, 0);
      wr(6'h30, 12'h000);
      idle(8, 0);

      // Random traffic near boundaries for all requirements
      for (int i = 0; i < 500; i++) begin
         int r;
         logic [31:0] d;
         logic [5:0] a;
         bit e;
         r = $urandom % 8;
         case ($urandom % 5)
            0: d = 32'hFFFF_FFFF - ($urandom % 4);
            1: d = $urandom % 6;
            2: d = {20'h0, 12'($urandom)};
            3: d = 32'($urandom);
            default: d = 32'h0;
         endcase
         a = 6'(($urandom % 16) * 4);
         e = bit'(($urandom % 3) == 0) ? ~ext_tick : ext_tick;
         if (r < 2) step(1, a, d, e);
         else       step(0, a, 0, e);
      end
      idle(4, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule